// File: doc/BRIEF.md
# Edge-Aligned Supply Switch Regulator

This block drives the switch that tops up the chip's own supply while the chip is in its operating mode. Three comparator flags describe the supply: above the hard upper limit, above the turn-on threshold, and below the turn-off threshold. A fourth input is the already-synchronized low-side gate command of the half bridge, and a fifth says whether the chip is in operating mode.

Outside operating mode the switch is held off. In operating mode the switch normally changes only on a falling edge of the low-side command, so that each change lines up with the switching cycle. An on or off request is stored until that edge arrives. If the supply passes the upper limit, the switch turns on at the next clock without waiting for an edge. Between the two thresholds the switch keeps its state, which gives the hysteresis that holds the supply inside the band.

Top module: `supply_sw_reg`

## Requirements
- R1: While `op_mode` is low at a clock edge, `sw_on` is 0 after that edge and any stored request is discarded.
- R2: In operating mode, `vcc_over_max` high at a clock edge makes `sw_on` 1 after that same edge, with or without a gate-command edge.
- R3: In operating mode, an on request makes `sw_on` 1 at the next falling edge of `ls_cmd`. An on request comes from `vcc_above_on` high, which wins when both threshold flags are high.
- R4: In operating mode, an off request makes `sw_on` 0 at the next falling edge of `ls_cmd`. An off request comes from `vcc_below_off` high.
- R5: A falling edge is `ls_cmd` sampled 1 at one clock and 0 at the next. Holding `ls_cmd` low gives no further edge. Apart from R1 and R2, `sw_on` never changes on a clock without a falling edge.
- R6: When both threshold flags are low (hysteresis band) and no request is stored, `sw_on` keeps its state, including across a falling edge.
- R7: A request is stored until a falling edge applies it and is then cleared. A later request in the opposite direction replaces it, so the earlier one is dropped.
- R8: Synchronous reset sets `sw_on` to 0, clears any stored request and clears the stored copy of `ls_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 1 | High while the chip is in operating mode |
| vcc_over_max | input | 1 | Supply is above the hard upper limit |
| vcc_above_on | input | 1 | Supply is above the turn-on threshold |
| vcc_below_off | input | 1 | Supply is below the turn-off threshold |
| ls_cmd | input | 1 | Synchronized low-side gate command |
| sw_on | output | 1 | Registered supply switch control |

## Verification
A vector walk drives threshold flags both steady and changing while the gate command toggles. This separates a switch that follows the level of the command from one that waits for a true falling edge, and it shows that holding the command low gives no second edge. Opposite requests issued before a single edge show whether the stored request is replaced or merely added to. A request issued just before the mode drops shows whether leaving operating mode clears it. An upper-limit flag raised with the command held low shows whether the immediate turn-on skips the edge. Directed cases then check reset in the middle of a run and a threshold flag that arrives on the same clock as the edge.

// File: rtl/sswr_pkg.sv
package sswr_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_ON   = 2'd1,
    REQ_OFF  = 2'd2
  } sw_req_t;
endpackage

// File: rtl/sswr_edge_det.sv
module sswr_edge_det #(
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  output logic fall
);
  logic cmd_q;

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= RST_LEVEL;
    else     cmd_q <= cmd;
  end

  assign fall = cmd_q & ~cmd;

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (fall && !cmd) |=> !fall); // R5
endmodule

// File: rtl/sswr_req_track.sv
module sswr_req_track
  import sswr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    op_mode,
  input  logic    above_on,
  input  logic    below_off,
  input  logic    apply,
  output sw_req_t req_eff,
  output sw_req_t req_q
);
  always_comb begin
    if (above_on)       req_eff = REQ_ON;
    else if (below_off) req_eff = REQ_OFF;
    else                req_eff = req_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           req_q <= REQ_NONE;
    else if (!op_mode) req_q <= REQ_NONE;
    else if (apply)    req_q <= REQ_NONE;
    else               req_q <= req_eff;
  end

  AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (apply || !op_mode) |=> (req_q == REQ_NONE)); // R7
endmodule

// File: rtl/sswr_switch_ctl.sv
module sswr_switch_ctl
  import sswr_pkg::*;
#(
  parameter logic SW_RST = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    op_mode,
  input  logic    over_max,
  input  logic    fall,
  input  sw_req_t req_eff,
  output logic    sw_q
);
  always_ff @(posedge clk) begin
    if (rst)                sw_q <= SW_RST;
    else if (!op_mode)      sw_q <= 1'b0;
    else if (over_max)      sw_q <= 1'b1;
    else if (fall) begin
      if (req_eff == REQ_ON)       sw_q <= 1'b1;
      else if (req_eff == REQ_OFF) sw_q <= 1'b0;
    end
  end

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !op_mode |=> !sw_q); // R1
  AST_MAX_FORCE: assert property (@(posedge clk) disable iff (rst)
    (op_mode && over_max) |=> sw_q); // R2
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (op_mode && !over_max && !fall) |=> $stable(sw_q)); // R5
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_mode && !over_max && req_eff == REQ_NONE) |=> $stable(sw_q)); // R6
endmodule

// File: rtl/supply_sw_reg.sv
module supply_sw_reg
  import sswr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_mode,
  input  logic vcc_over_max,
  input  logic vcc_above_on,
  input  logic vcc_below_off,
  input  logic ls_cmd,
  output logic sw_on
);
  logic    fall;
  sw_req_t req_eff;
  sw_req_t req_q;

  sswr_edge_det #(.RST_LEVEL(1'b0)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .cmd  (ls_cmd),
    .fall (fall)
  );

  sswr_req_track u_req (
    .clk       (clk),
    .rst       (rst),
    .op_mode   (op_mode),
    .above_on  (vcc_above_on),
    .below_off (vcc_below_off),
    .apply     (fall),
    .req_eff   (req_eff),
    .req_q     (req_q)
  );

  sswr_switch_ctl #(.SW_RST(1'b0)) u_sw (
    .clk      (clk),
    .rst      (rst),
    .op_mode  (op_mode),
    .over_max (vcc_over_max),
    .fall     (fall),
    .req_eff  (req_eff),
    .sw_q     (sw_on)
  );

  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (!sw_on && req_q == REQ_NONE)); // R8
endmodule

// File: tb/supply_sw_reg_tb_top.sv
module supply_sw_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_mode = 1'b0, vcc_over_max = 1'b0, vcc_above_on = 1'b0;
  logic vcc_below_off = 1'b0, ls_cmd = 1'b0;
  logic sw_on;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  supply_sw_reg dut_i (
    .clk(clk), .rst(rst), .op_mode(op_mode), .vcc_over_max(vcc_over_max),
    .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
    .ls_cmd(ls_cmd), .sw_on(sw_on)
  );

  // {run, max, on, off, ls, expected sw, requirement tag[3:0]}
  localparam int NV = 24;
  localparam logic [9:0] VEC [NV] = '{
    {6'b10001_0, 4'd6}, // R6 band, ls high
    {6'b10101_0, 4'd5}, // R5 on request, no edge yet
    {6'b10000_1, 4'd3}, // R3 edge applies stored on
    {6'b10001_1, 4'd6}, // R6 hold
    {6'b10011_1, 4'd5}, // R5 off request waits
    {6'b10000_0, 4'd4}, // R4 edge applies stored off
    {6'b10011_0, 4'd4}, // R4
    {6'b10101_0, 4'd7}, // R7 on request
    {6'b10011_0, 4'd7}, // R7 reversed to off
    {6'b10000_0, 4'd7}, // R7 edge: on dropped
    {6'b11100_1, 4'd2}, // R2 immediate on, no edge
    {6'b10000_1, 4'd6}, // R6 hold
    {6'b10011_1, 4'd5}, // R5 off request
    {6'b00000_0, 4'd1}, // R1 leave mode, edge ignored
    {6'b10001_0, 4'd1}, // R1 back in mode
    {6'b10000_0, 4'd1}, // R1 request was cleared
    {6'b01100_0, 4'd1}, // R1 upper limit ignored outside mode
    {6'b10100_0, 4'd5}, // R5 ls low held, no edge
    {6'b10000_0, 4'd5}, // R5 still no edge
    {6'b10001_0, 4'd5}, // R5 ls high
    {6'b10000_1, 4'd7}, // R7 stored on kept through band
    {6'b10011_1, 4'd4}, // R4 off request
    {6'b10010_0, 4'd4}, // R4 off at edge with live flag
    {6'b10100_0, 4'd5}  // R5 no second edge
  };

  task automatic check(input logic exp, input int tag);
    n_chk++;
    if (sw_on !== exp) begin
      n_bad++;
      $display("FAIL R%0d: sw_on=%b expected=%b", tag, sw_on, exp);
    end
  endtask

  task automatic step(input logic [4:0] in);
    @(negedge clk);
    {op_mode, vcc_over_max, vcc_above_on, vcc_below_off, ls_cmd} = in;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, 8); // R8 reset value
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:5]);
      check(VEC[i][4], int'(VEC[i][3:0]));
    end
    // R3: on flag arrives on the same clock as the edge
    step(5'b10001);
    step(5'b10100);
    check(1'b1, 3);
    // R3: both threshold flags high, on wins
    step(5'b10011);
    step(5'b10000);
    check(1'b0, 4);
    step(5'b10111);
    step(5'b10110);
    check(1'b1, 3);
    // R8: mid-run reset with off request pending
    step(5'b10011);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(1'b0, 8);
    @(negedge clk);
    rst = 1'b0;
    step(5'b10000);
    check(1'b0, 8); // R8 copy of ls cleared: no edge
    step(5'b10001);
    step(5'b10000);
    check(1'b0, 8); // R8 request cleared by reset
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule